// File: doc/BRIEF.md
# Ring Sampler Delayed-Stop Readout Controller

This block is the digital control for a circular analog sampling array. A write position walks around a ring of cells, one step per sample tick. The ring depth is a base of 1024 cells, multiplied by 1, 2, 4 or 8 when channels are cascaded. A depth-mode input selects the multiple.

A trigger does not freeze the ring at once. The controller first lets a programmable number of further sample ticks pass, which places the stored window relative to the trigger. It then halts the ring and records the cell it stopped on. Readout starts from that cell rather than from cell 0 and wraps around the ring. It covers only a programmable region of interest, one cell per readout strobe, which keeps dead time short.

When the last cell of the region has been read, the controller reports completion and resumes sampling from cell 0. The controller steps the external digitiser through `rd_addr` and tells the rest of the system when it cannot accept a trigger.

Top module: `sca_stop_ctrl`

## Requirements
- R1: After reset, `wr_pos` is 0, `busy`, `rd_valid` and `done` are low, and `ign_count` is 0.
- R2: While sampling, `wr_pos` advances by one on each cycle with `sample_tick` high and holds otherwise. It wraps to 0 after cell depth-1, where depth is 1024 << `depth_mode` (0 gives 1024, 1 gives 2048, 2 gives 4096, 3 gives 8192).
- R3: A trigger while sampling raises `busy` in the next cycle. The cycle's own tick still advances the ring. The ring then takes exactly `stop_delay` further ticks and stops in the following cycle. `stop_cell` becomes (P + 1 + `stop_delay`) mod depth, where P is `wr_pos` in the trigger cycle, assuming a tick every cycle.
- R4: From the stop until `done`, `wr_pos` does not change, whatever `sample_tick` does.
- R5: During readout, `rd_valid` is high and `rd_addr` starts at `stop_cell`. Each `rd_strobe` moves `rd_addr` up by one, wrapping modulo the depth chosen at the trigger.
- R6: After exactly the region length's worth of strobes, `done` is high for one cycle. In that cycle `busy` and `rd_valid` are low, and sampling restarts at `wr_pos` = 0.
- R7: A region length of 0, or one greater than the ring depth, is treated as the full ring depth.
- R8: A trigger while `busy` is high is ignored: the stop cell and readout are unchanged, and `ign_count` increments, saturating at its maximum.
- R9: `rd_strobe` while sampling has no effect: `rd_valid`, `done` and `busy` stay low, and the next readout still covers the full region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle sample clock enable |
| trig | input | 1 | Trigger request |
| depth_mode | input | 2 | Cascade depth select: depth = 1024 << value |
| stop_delay | input | 16 | Sample ticks between trigger and stop |
| roi_len | input | 14 | Region-of-interest length in cells |
| rd_strobe | input | 1 | Readout strobe, one cell per strobe |
| wr_pos | output | 13 | Current write position of the ring |
| stop_cell | output | 13 | Cell at which the ring stopped |
| rd_addr | output | 13 | Cell address being read |
| rd_valid | output | 1 | Readout in progress, `rd_addr` valid |
| done | output | 1 | One-cycle pulse after the last region cell |
| busy | output | 1 | Delay or readout in progress |
| ign_count | output | 8 | Saturating count of ignored triggers |

## Verification
Several behaviours are checked by properties on every cycle:
- `done` lasts a single cycle, coincides with an idle controller and a cleared ring, and follows a strobe.
- The read address stays inside the latched depth and steps by one per strobe.
- The write position holds still through readout.
- Ignored triggers increment the counter.

Some behaviours only the directed scenarios can show. These are the exact stop cell relative to the trigger position and delay, wrap-around at the ring boundary in several depth modes, the clamping of zero and oversized region lengths, and that stray strobes or extra triggers leave the captured window untouched.

// File: rtl/sca_pkg.sv
package sca_pkg;

    typedef enum logic [1:0] {
        PH_SAMPLE = 2'd0,
        PH_DELAY  = 2'd1,
        PH_READ   = 2'd2
    } phase_e;

endpackage

// File: rtl/sca_depth_cfg.sv
module sca_depth_cfg #(
    parameter int BASE_DEPTH = 1024,
    parameter int MODE_W     = 2,
    parameter int ADDR_W     = 13,
    parameter int ROI_W      = 14
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [ROI_W-1:0]  roi_len,
    output logic [ADDR_W-1:0] mask,
    output logic [ROI_W-1:0]  roi_eff
);
    localparam int N_MODES = 1 << MODE_W;

    logic [ROI_W-1:0] depth_tbl [N_MODES];

    for (genvar m = 0; m < N_MODES; m++) begin : g_depth
        assign depth_tbl[m] = ROI_W'(BASE_DEPTH << m);
    end

    logic [ROI_W-1:0] depth;

    always_comb begin
        depth = depth_tbl[mode];
        mask  = ADDR_W'(depth - ROI_W'(1));
        if (roi_len == '0 || roi_len > depth) begin
            roi_eff = depth;
        end else begin
            roi_eff = roi_len;
        end
    end

endmodule

// File: rtl/sca_ring_pos.sv
module sca_ring_pos #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              clear,
    input  logic [ADDR_W-1:0] mask,
    output logic [ADDR_W-1:0] pos
);
    typedef struct packed {
        logic [ADDR_W-1:0] pos;
    } ring_t;

    ring_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clear) begin
            nxt_d.pos = '0;
        end else if (advance) begin
            nxt_d.pos = (cur_q.pos + ADDR_W'(1)) & mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pos = cur_q.pos;

    // R4: with neither advance nor clear the position holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !clear) |=> $stable(cur_q.pos));

    // R6: clear always lands on cell 0
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cur_q.pos == '0));

endmodule

// File: rtl/sca_roi_walker.sv
module sca_roi_walker #(
    parameter int ADDR_W = 13,
    parameter int ROI_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ROI_W-1:0]  length,
    input  logic              step,
    input  logic [ADDR_W-1:0] mask,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ROI_W-1:0]  left;
    } walk_t;

    walk_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.addr = start_addr;
            nxt_d.left = length;
        end else if (step) begin
            nxt_d.addr = (cur_q.addr + ADDR_W'(1)) & mask;
            if (cur_q.left != '0) begin
                nxt_d.left = cur_q.left - ROI_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign addr = cur_q.addr;
    assign last = (cur_q.left == ROI_W'(1));

    // R5: a step moves the address up by one inside the ring
    a_r5_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cur_q.addr == ((($past(cur_q.addr)) + ADDR_W'(1)) & $past(mask))));

    // R5: the address never leaves the masked ring range
    a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> ((cur_q.addr & ~($past(mask))) == '0));

endmodule

// File: rtl/sca_stop_ctrl.sv
module sca_stop_ctrl
    import sca_pkg::*;
#(
    parameter int BASE_DEPTH = 1024,
    parameter int MODE_W     = 2,
    parameter int DELAY_W    = 16,
    parameter int IGN_W      = 8,
    localparam int ADDR_W    = $clog2(BASE_DEPTH) + (1 << MODE_W) - 1,
    localparam int ROI_W     = ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_tick,
    input  logic               trig,
    input  logic [MODE_W-1:0]  depth_mode,
    input  logic [DELAY_W-1:0] stop_delay,
    input  logic [ROI_W-1:0]   roi_len,
    input  logic               rd_strobe,
    output logic [ADDR_W-1:0]  wr_pos,
    output logic [ADDR_W-1:0]  stop_cell,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic               rd_valid,
    output logic               done,
    output logic               busy,
    output logic [IGN_W-1:0]   ign_count
);
    typedef struct packed {
        phase_e             phase;
        logic [DELAY_W-1:0] wait_cnt;
        logic [MODE_W-1:0]  mode;
        logic [ADDR_W-1:0]  stop_cell;
        logic               done;
        logic [IGN_W-1:0]   ign;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    logic [MODE_W-1:0] mode_sel;
    logic [ADDR_W-1:0] ring_mask;
    logic [ROI_W-1:0]  roi_eff;
    logic              ring_adv;
    logic              ring_clr;
    logic              walk_load;
    logic              walk_step;
    logic              walk_last;
    logic [ADDR_W-1:0] pos_w;
    logic [ADDR_W-1:0] walk_addr;

    assign mode_sel = (cur_q.phase == PH_SAMPLE) ? depth_mode : cur_q.mode;

    sca_depth_cfg #(
        .BASE_DEPTH (BASE_DEPTH),
        .MODE_W     (MODE_W),
        .ADDR_W     (ADDR_W),
        .ROI_W      (ROI_W)
    ) u_cfg (
        .mode    (mode_sel),
        .roi_len (roi_len),
        .mask    (ring_mask),
        .roi_eff (roi_eff)
    );

    sca_ring_pos #(
        .ADDR_W (ADDR_W)
    ) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (ring_adv),
        .clear   (ring_clr),
        .mask    (ring_mask),
        .pos     (pos_w)
    );

    sca_roi_walker #(
        .ADDR_W (ADDR_W),
        .ROI_W  (ROI_W)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (walk_load),
        .start_addr (pos_w),
        .length     (roi_eff),
        .step       (walk_step),
        .mask       (ring_mask),
        .addr       (walk_addr),
        .last       (walk_last)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        ring_adv   = 1'b0;
        ring_clr   = 1'b0;
        walk_load  = 1'b0;
        walk_step  = 1'b0;

        if (trig && cur_q.phase != PH_SAMPLE && cur_q.ign != '1) begin
            nxt_d.ign = cur_q.ign + IGN_W'(1);
        end

        unique case (cur_q.phase)
            PH_SAMPLE: begin
                ring_adv = sample_tick;
                if (trig) begin
                    nxt_d.phase    = PH_DELAY;
                    nxt_d.wait_cnt = stop_delay;
                    nxt_d.mode     = depth_mode;
                end
            end
            PH_DELAY: begin
                if (cur_q.wait_cnt == '0) begin
                    nxt_d.phase     = PH_READ;
                    nxt_d.stop_cell = pos_w;
                    walk_load       = 1'b1;
                end else if (sample_tick) begin
                    ring_adv       = 1'b1;
                    nxt_d.wait_cnt = cur_q.wait_cnt - DELAY_W'(1);
                end
            end
            PH_READ: begin
                walk_step = rd_strobe;
                if (rd_strobe && walk_last) begin
                    nxt_d.phase = PH_SAMPLE;
                    nxt_d.done  = 1'b1;
                    ring_clr    = 1'b1;
                end
            end
            default: begin
                nxt_d.phase = PH_SAMPLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.phase <= PH_SAMPLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign wr_pos    = pos_w;
    assign stop_cell = cur_q.stop_cell;
    assign rd_addr   = walk_addr;
    assign rd_valid  = (cur_q.phase == PH_READ);
    assign busy      = (cur_q.phase != PH_SAMPLE);
    assign done      = cur_q.done;
    assign ign_count = cur_q.ign;

    // R6: completion is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: at completion the controller is idle and the ring is back at 0
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !rd_valid && wr_pos == '0));

    // R6: completion only follows a strobe during readout
    a_r6_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(rd_valid && rd_strobe));

    // R4: write position frozen while reading
    a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_valid)) |-> $stable(wr_pos));

    // R5: the first read address is the stop cell
    a_r5_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> (rd_addr == stop_cell));

    // R8: a trigger during busy bumps the ignore counter
    a_r8_count: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && busy && ign_count != '1) |=> (ign_count == $past(ign_count) + IGN_W'(1)));

    // R9: strobes while sampling start nothing
    a_r9_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !trig) |=> !rd_valid);

endmodule

// File: tb/sca_stop_ctrl_test.sv
module sca_stop_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_tick = 1'b0;
    logic        trig = 1'b0;
    logic [1:0]  depth_mode = '0;
    logic [15:0] stop_delay = '0;
    logic [13:0] roi_len = '0;
    logic        rd_strobe = 1'b0;
    logic [12:0] wr_pos;
    logic [12:0] stop_cell;
    logic [12:0] rd_addr;
    logic        rd_valid;
    logic        done;
    logic        busy;
    logic [7:0]  ign_count;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sca_stop_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .trig        (trig),
        .depth_mode  (depth_mode),
        .stop_delay  (stop_delay),
        .roi_len     (roi_len),
        .rd_strobe   (rd_strobe),
        .wr_pos      (wr_pos),
        .stop_cell   (stop_cell),
        .rd_addr     (rd_addr),
        .rd_valid    (rd_valid),
        .done        (done),
        .busy        (busy),
        .ign_count   (ign_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        cyc(2);
        chk(wr_pos == 0, "R1 wr_pos", wr_pos, 0);
        chk(!busy && !rd_valid && !done, "R1 flags", {busy, rd_valid, done}, 0);
        chk(ign_count == 0, "R1 ign_count", ign_count, 0);
        rst_n = 1'b1;
        cyc(1);
    endtask

    // R2: advance, hold, wrap in two depth modes
    task automatic t_wrap();
        int p0;
        depth_mode = 2'd0;
        sample_tick = 1'b0;
        cyc(3);
        chk(wr_pos == 0, "R2 hold without tick", wr_pos, 0);
        sample_tick = 1'b1;
        cyc(1030);
        chk(wr_pos == 6, "R2 wrap depth 1024", wr_pos, 6);
        sample_tick = 1'b0;
        p0 = wr_pos;
        cyc(4);
        chk(wr_pos == p0, "R2 hold after ticks", wr_pos, p0);
        depth_mode = 2'd1;
        sample_tick = 1'b1;
        cyc(2048);
        chk(wr_pos == ((p0 + 2048) % 2048), "R2 wrap depth 2048", wr_pos, (p0 + 2048) % 2048);
    endtask

    // R9: strobes while sampling do nothing
    task automatic t_stray_strobe();
        rd_strobe = 1'b1;
        cyc(5);
        chk(!rd_valid && !done && !busy, "R9 stray strobe", {rd_valid, done, busy}, 0);
        rd_strobe = 1'b0;
    endtask

    task automatic t_capture(input string tag, input int mode, input int dly, input int roi,
                             input int exp_len, input int lead,
                             input bit ign_delay, input bit ign_read);
        int depth, p, exp_stop, n, k, addr_err, pos_err, ign0, exp_ign;
        depth = 1024 << mode;
        depth_mode = mode[1:0];
        stop_delay = dly[15:0];
        roi_len = roi[13:0];
        sample_tick = 1'b1;
        cyc(lead);
        p = wr_pos;
        ign0 = ign_count;
        exp_stop = (p + 1 + dly) % depth;
        trig = 1'b1;
        cyc(1);
        trig = 1'b0;
        chk(busy && !rd_valid, {tag, " R3 busy after trigger"}, busy, 1);
        n = 1;
        while (!rd_valid && n < 70000) begin
            trig = (n == 1) && ign_delay;
            cyc(1);
            n++;
        end
        trig = 1'b0;
        chk(n == dly + 2, {tag, " R3 stop timing"}, n, dly + 2);
        chk(stop_cell == exp_stop, {tag, " R3 stop cell"}, stop_cell, exp_stop);
        chk(rd_addr == exp_stop, {tag, " R5 first address"}, rd_addr, exp_stop);
        addr_err = 0;
        pos_err = 0;
        k = 0;
        while (k < exp_len && rd_valid) begin
            if (rd_addr != (exp_stop + k) % depth) addr_err++;
            if (wr_pos != exp_stop) pos_err++;
            sample_tick = k[0];
            rd_strobe = 1'b1;
            trig = (k == 0) && ign_read;
            cyc(1);
            trig = 1'b0;
            k++;
        end
        rd_strobe = 1'b0;
        sample_tick = 1'b1;
        chk(addr_err == 0, {tag, " R5 address walk"}, addr_err, 0);
        chk(pos_err == 0, {tag, " R4 ring frozen"}, pos_err, 0);
        chk(k == exp_len, {tag, " R6/R7 region length"}, k, exp_len);
        chk(done && !busy && !rd_valid, {tag, " R6 done state"}, {done, busy, rd_valid}, 4);
        chk(wr_pos == 0, {tag, " R6 restart at 0"}, wr_pos, 0);
        cyc(1);
        chk(!done, {tag, " R6 done one cycle"}, done, 0);
        chk(wr_pos == 1, {tag, " R6 sampling resumed"}, wr_pos, 1);
        exp_ign = ign0 + int'(ign_delay) + int'(ign_read);
        chk(ign_count == exp_ign, {tag, " R8 ignore count"}, ign_count, exp_ign);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        t_reset();
        t_wrap();
        t_stray_strobe();
        // R3 R5: stop near the top of a 1024 ring, readout wraps to 0
        t_capture("wrap", 0, 3, 4, 4, 1017 - int'(wr_pos) + 1024 * (wr_pos > 1017 ? 1 : 0), 1'b0, 1'b0);
        // R3: zero delay in the 4096 ring
        t_capture("nodelay", 2, 0, 3, 3, 40, 1'b0, 1'b0);
        // R8: triggers during delay and readout are ignored
        t_capture("ignore", 1, 10, 6, 6, 17, 1'b1, 1'b1);
        // R7: zero length clamps to the full 1024 ring
        t_capture("clamp0", 0, 2, 0, 1024, 5, 1'b0, 1'b0);
        // R7: oversized length clamps to the full 2048 ring
        t_capture("clampbig", 1, 1, 5000, 2048, 9, 1'b0, 1'b0);
        // R3 R5: deepest ring, wrap on the 8192 boundary
        t_capture("deep", 3, 4, 8, 8, 8185, 1'b0, 1'b0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule